// File: doc/BRIEF.md
# Hardware Dynamic Job Dispatcher

The dispatcher hands out job numbers to a fixed set of processors that share a pool of jobs numbered 0 up to a last job number. When a processor finishes a job, it raises a request on its own port. In each clock cycle the dispatcher accepts at most one request and answers that port with a job number. No two processors ever get the same number.

In dynamic mode, each processor's first request returns its own port index. Every later request takes the value of a shared next-job counter and increments that counter in the same step. In static mode, each port works through its own stride: its port index first, then that index plus the port count, and so on. When a port's next number would exceed the last job, the dispatcher answers with a done flag instead of a job.

The request side is a valid/ready handshake per port. A processor raises `req_valid[p]` and must hold it until it sees `req_ready[p]` high at a rising edge. The dispatcher applies back-pressure simply by leaving `req_ready` low for any port it does not pick in that cycle. The answer has no back-pressure: it is a one-cycle `rsp_valid` pulse that the processor must capture.

The last job number and the mode come from parameters at reset. A `start` pulse reloads them from the configuration pins and rearms all counters. `start` takes effect only in a cycle with no request raised.

Top module: `job_dispatcher`

## Requirements
- R1: In dynamic mode, after reset or an accepted start, the first answer to port p carries job p when p is at most the last job number, and carries the done flag otherwise.
- R2: In dynamic mode, the shared counter starts at the port count NPROC. Every later answer that is not done carries the counter value, and the counter then increases by one. Over a complete run, every job from 0 to the last job is handed out exactly once.
- R3: An answer whose number would exceed the last job number has `rsp_done`=1 and `rsp_job`=0. It leaves the counter unchanged, so every later request to that counter is also answered as done.
- R4: In static mode, port p receives jobs p, p+NPROC, p+2·NPROC and so on, each at most the last job number, and then only done answers.
- R5: `req_ready` has at most one bit set per cycle, only on a port whose `req_valid` is high. It has a bit set whenever any request is raised.
- R6: Arbitration is round-robin. The pointer starts at port 0. The grant goes to the first requesting port at or after the pointer, counting upward and wrapping. The pointer then moves to one past the granted port. A start does not move the pointer.
- R7: A handshake on port p at a rising edge gives `rsp_valid` equal to only bit p, with the job and done values, during the next cycle. With no handshake, `rsp_valid` is 0.
- R8: `start` loads `cfg_last` (the last job number) and `cfg_static` (1 = static mode). It rearms the first jobs and counters only if `req_valid` is all zero in that cycle. Otherwise it is ignored and the current run continues unchanged.
- R9: Reset clears `rsp_valid`, sets the pointer to 0, and loads last job DEF_LAST and mode DEF_STATIC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load configuration and rearm, honoured only with no request raised |
| cfg_last | input | JOB_W | Last job number to load on start |
| cfg_static | input | 1 | Mode to load on start: 1 static stride, 0 dynamic counter |
| req_valid | input | NPROC | Per-port job request, held until accepted |
| req_ready | output | NPROC | Per-port acceptance, at most one bit set |
| rsp_valid | output | NPROC | One-cycle answer pulse on the accepted port |
| rsp_job | output | JOB_W | Job number of the current answer, 0 when done |
| rsp_done | output | 1 | Current answer says the work is exhausted |

## Verification
Several properties are checked every cycle by assertions:
- at most one grant, and only to a requester;
- work conservation, and a granted port yielding to other requesters in the following cycle;
- the answer pulse following exactly the handshake;
- the shared counter advancing by one per live grant and standing still once past the last job;
- static answers belonging to the answering port's stride.

Other behaviour can only be shown by the bench's scenarios, which track a reference model:
- the exact job sequence;
- that a full run hands out every job exactly once;
- the first-job rule when the last job is smaller than the port count;
- that a start arriving alongside a request is ignored.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

  // index width that stays legal for a single port
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

  // counter width able to hold last job plus one full stride
  function automatic int cnt_width(input int job_w, input int count);
    return $clog2((1 << job_w) + count);
  endfunction

endpackage

// File: rtl/dispatch_rr_arbiter.sv
module dispatch_rr_arbiter #(
  parameter int NPROC  = 4,
  parameter int PIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPROC-1:0]  req,
  output logic [NPROC-1:0]  gnt,
  output logic [PIDX_W-1:0] gnt_idx,
  output logic              any
);

  logic [PIDX_W-1:0] ptr_q;

  always_comb begin
    int cand;
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    cand    = 0;
    for (int i = 0; i < NPROC; i++) begin
      cand = int'(ptr_q) + i;
      if (cand >= NPROC) cand = cand - NPROC;
      if (!any && req[cand]) begin
        any       = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = PIDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (any) begin
      if (int'(gnt_idx) == NPROC - 1) ptr_q <= '0;
      else                            ptr_q <= gnt_idx + PIDX_W'(1);
    end
  end

  assert_one_grant_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  assert_grant_to_requester_R5: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
  assert_work_conserving_R5: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|gnt));

  generate
    for (genvar p = 0; p < NPROC; p++) begin : g_yield
      assert_rr_yield_R6: assert property (@(posedge clk) disable iff (rst)
        gnt[p] |=> !(gnt[p] && ((req & ~(NPROC'(1) << p)) != '0)));
    end
  endgenerate

endmodule

// File: rtl/dispatch_job_source.sv
module dispatch_job_source
  import dispatch_pkg::*;
#(
  parameter int NPROC      = 4,
  parameter int JOB_W      = 6,
  parameter int PIDX_W     = 2,
  parameter int DEF_LAST   = 20,
  parameter bit DEF_STATIC = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [JOB_W-1:0]  load_last,
  input  logic              load_static,
  input  logic              take,
  input  logic [PIDX_W-1:0] take_idx,
  output logic [JOB_W-1:0]  job,
  output logic              done,
  output logic              mode_static
);

  localparam int CNT_W = cnt_width(JOB_W, NPROC);

  logic [JOB_W-1:0] last_q;
  logic             static_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NPROC-1:0] first_q;
  logic [CNT_W-1:0] nxt_q [NPROC];
  logic [CNT_W-1:0] cand;

  always_comb begin
    if (static_q)               cand = nxt_q[take_idx];
    else if (first_q[take_idx]) cand = cnt_q;
    else                        cand = CNT_W'(take_idx);
    done = cand > CNT_W'(last_q);
    job  = done ? '0 : cand[JOB_W-1:0];
  end

  assign mode_static = static_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      last_q   <= rst ? JOB_W'(DEF_LAST) : load_last;
      static_q <= rst ? DEF_STATIC : load_static;
      cnt_q    <= CNT_W'(NPROC);
      first_q  <= '0;
      for (int p = 0; p < NPROC; p++) nxt_q[p] <= CNT_W'(p);
    end else if (take) begin
      first_q[take_idx] <= 1'b1;
      if (!done) begin
        if (static_q)               nxt_q[take_idx] <= nxt_q[take_idx] + CNT_W'(NPROC);
        else if (first_q[take_idx]) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assert_counter_step_R2: assert property (@(posedge clk) disable iff (rst)
    (take && !load && !static_q && first_q[take_idx] && !done) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q > CNT_W'(last_q)) |=> $stable(cnt_q));

endmodule

// File: rtl/job_dispatcher.sv
module job_dispatcher
  import dispatch_pkg::*;
#(
  parameter int NPROC      = 4,
  parameter int MAX_JOB    = 63,
  parameter int DEF_LAST   = 20,
  parameter bit DEF_STATIC = 1'b0,
  localparam int JOB_W     = $clog2(MAX_JOB + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [JOB_W-1:0] cfg_last,
  input  logic             cfg_static,
  input  logic [NPROC-1:0] req_valid,
  output logic [NPROC-1:0] req_ready,
  output logic [NPROC-1:0] rsp_valid,
  output logic [JOB_W-1:0] rsp_job,
  output logic             rsp_done
);

  localparam int PIDX_W = idx_width(NPROC);

  logic [NPROC-1:0]  gnt;
  logic [PIDX_W-1:0] gnt_idx;
  logic              any_gnt;
  logic [JOB_W-1:0]  src_job;
  logic              src_done;
  logic              src_static;
  logic              load;
  logic [PIDX_W-1:0] rsp_idx_q;

  assign load = start && (req_valid == '0);

  dispatch_rr_arbiter #(.NPROC(NPROC), .PIDX_W(PIDX_W)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (req_valid),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any_gnt)
  );

  dispatch_job_source #(
    .NPROC(NPROC), .JOB_W(JOB_W), .PIDX_W(PIDX_W),
    .DEF_LAST(DEF_LAST), .DEF_STATIC(DEF_STATIC)
  ) u_src (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .load_last   (cfg_last),
    .load_static (cfg_static),
    .take        (any_gnt),
    .take_idx    (gnt_idx),
    .job         (src_job),
    .done        (src_done),
    .mode_static (src_static)
  );

  assign req_ready = gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_job   <= '0;
      rsp_done  <= 1'b0;
      rsp_idx_q <= '0;
    end else begin
      rsp_valid <= req_valid & gnt;
      rsp_job   <= any_gnt ? src_job : '0;
      rsp_done  <= any_gnt && src_done;
      rsp_idx_q <= gnt_idx;
    end
  end

  assert_rsp_follows_handshake_R7: assert property (@(posedge clk) disable iff (rst)
    (|(req_valid & req_ready)) |=> rsp_valid == $past(req_valid & req_ready));
  assert_no_spurious_rsp_R7: assert property (@(posedge clk) disable iff (rst)
    ((req_valid & req_ready) == '0) |=> rsp_valid == '0);
  assert_static_owner_R4: assert property (@(posedge clk) disable iff (rst)
    (|rsp_valid && !rsp_done && src_static && !$past(load))
      |-> (int'(rsp_job) % NPROC) == int'(rsp_idx_q));

endmodule

// File: tb/test_job_dispatcher.sv
`timescale 1ns/1ps
module test_job_dispatcher;
  localparam int NPROC    = 4;
  localparam int MAX_JOB  = 63;
  localparam int JOB_W    = 6;
  localparam int DEF_LAST = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst;
  logic             start;
  logic [JOB_W-1:0] cfg_last;
  logic             cfg_static;
  logic [NPROC-1:0] req_valid;
  logic [NPROC-1:0] req_ready;
  logic [NPROC-1:0] rsp_valid;
  logic [JOB_W-1:0] rsp_job;
  logic             rsp_done;

  job_dispatcher #(.NPROC(NPROC), .MAX_JOB(MAX_JOB), .DEF_LAST(DEF_LAST), .DEF_STATIC(1'b0))
    i_job_dispatcher (
      .clk(clk), .rst(rst), .start(start), .cfg_last(cfg_last), .cfg_static(cfg_static),
      .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_job(rsp_job), .rsp_done(rsp_done));

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model
  int m_last, m_cnt, m_ptr;
  bit m_static;
  bit [NPROC-1:0] m_first;
  int m_nxt [NPROC];
  bit seen [64];
  int seen_cnt;
  logic [NPROC-1:0] pend;
  logic [NPROC-1:0] exp_rv;
  int exp_job;
  bit exp_done;
  string exp_tag;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model_load(input int last, input bit st);
    m_last = last; m_static = st; m_cnt = NPROC; m_first = '0;
    for (int p = 0; p < NPROC; p++) m_nxt[p] = p;
    for (int j = 0; j < 64; j++) seen[j] = 0;
    seen_cnt = 0;
  endfunction

  function automatic int rr_pick(input logic [NPROC-1:0] r);
    for (int i = 0; i < NPROC; i++) begin
      int c = (m_ptr + i) % NPROC;
      if (r[c]) return c;
    end
    return -1;
  endfunction

  task automatic cycle(input logic [NPROC-1:0] add, input bit do_start, input int last, input bit st);
    int g;
    int cand;
    logic [NPROC-1:0] exp_rdy;
    check(rsp_valid == exp_rv, "R7", rsp_valid, exp_rv);
    if (exp_rv != '0) begin
      check(rsp_done == exp_done, "R3", rsp_done, exp_done);
      check(rsp_job == JOB_W'(exp_job), exp_tag, rsp_job, exp_job);
    end
    pend = pend | add;
    req_valid = pend; start = do_start; cfg_last = JOB_W'(last); cfg_static = st;
    #1;
    g = rr_pick(pend);
    exp_rdy = (g < 0) ? '0 : (NPROC'(1) << g);
    check(req_ready == exp_rdy, "R6", req_ready, exp_rdy);
    if (g >= 0) begin
      if (m_static) begin cand = m_nxt[g]; exp_tag = "R4"; end
      else if (m_first[g]) begin cand = m_cnt; exp_tag = "R2"; end
      else begin cand = g; exp_tag = "R1"; end
      exp_done = cand > m_last;
      exp_job  = exp_done ? 0 : cand;
      if (exp_done) exp_tag = "R3";
      m_first[g] = 1'b1;
      if (!exp_done) begin
        if (m_static) m_nxt[g] = m_nxt[g] + NPROC;
        else if (cand == m_cnt && exp_tag == "R2") m_cnt++;
        if (seen[cand]) begin
          n_checks++; n_fail++;
          $display("FAIL R2: actual job %0d handed out twice expected once", cand);
        end
        seen[cand] = 1; seen_cnt++;
      end
      exp_rv = exp_rdy;
      pend[g] = 1'b0;
      m_ptr = (g + 1) % NPROC;
    end else begin
      exp_rv = '0;
      if (do_start && pend == '0) model_load(last, st);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_random(input int cycles, input int pct);
    for (int c = 0; c < cycles; c++) begin
      logic [NPROC-1:0] add;
      for (int p = 0; p < NPROC; p++) add[p] = (($urandom % 100) < pct);
      cycle(add, 1'b0, 0, 1'b0);
    end
  endtask

  task automatic drain();
    while (pend != '0) cycle('0, 1'b0, 0, 1'b0);
    cycle('0, 1'b0, 0, 1'b0);
  endtask

  task automatic restart(input int last, input bit st);
    drain();
    cycle('0, 1'b1, last, st);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; start = 1'b0; cfg_last = '0; cfg_static = 1'b0; req_valid = '0;
    pend = '0; exp_rv = '0; exp_job = 0; exp_done = 0; exp_tag = "R1"; m_ptr = 0;
    model_load(DEF_LAST, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(rsp_valid == '0, "R9", rsp_valid, 0);
    check(req_ready == '0, "R9", req_ready, 0);
    // R1 directed first job, then R2 counter at NPROC
    cycle(4'b0100, 1'b0, 0, 1'b0);
    cycle(4'b0100, 1'b0, 0, 1'b0);
    cycle(4'b0000, 1'b0, 0, 1'b0);
    check(exp_job == NPROC, "R2", exp_job, NPROC);
    // R6 all ports at once
    cycle(4'b1111, 1'b0, 0, 1'b0);
    // full dynamic run with default last job
    run_random(200, 40);
    drain();
    check(seen_cnt == DEF_LAST + 1, "R2", seen_cnt, DEF_LAST + 1);
    // R4 static run
    restart(13, 1'b1);
    run_random(120, 50);
    drain();
    check(seen_cnt == 14, "R4", seen_cnt, 14);
    // R8 start with a request pending is ignored
    restart(30, 1'b1);
    cycle(4'b0001, 1'b1, 5, 1'b0);
    cycle(4'b0001, 1'b0, 0, 1'b0);
    cycle(4'b0000, 1'b0, 0, 1'b0);
    check(exp_job == 4, "R8", exp_job, 4);
    // R1 / R3 boundary: last job below port count
    restart(2, 1'b0);
    cycle(4'b1000, 1'b0, 0, 1'b0);
    cycle(4'b0000, 1'b0, 0, 1'b0);
    check(exp_done == 1'b1, "R3", exp_done, 1);
    cycle(4'b0111, 1'b0, 0, 1'b0);
    run_random(20, 60);
    drain();
    check(seen_cnt == 3, "R1", seen_cnt, 3);
    // random configurations
    for (int k = 0; k < 6; k++) begin
      int last = $urandom % 48;
      bit st = $urandom % 2;
      restart(last, st);
      run_random(last + 60, 30 + ($urandom % 60));
      drain();
      check(seen_cnt == last + 1, st ? "R4" : "R2", seen_cnt, last + 1);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule